// File: doc/BRIEF.md
# Non-Overwriting Event Memory with Serial Readout

This block collects one result per bunch crossing while an acquisition window is open. Each accepted result becomes a 72-bit word in a 96-entry store. The word is laid out according to the selected mode: stub mode packs up to four 13-bit stubs, and raw-hit mode carries a 48-bit hit vector. In both modes the word also holds the 16-bit bunch-crossing number and a run of all-ones marker bits at the top. Events that carry nothing are dropped. Once the store is full it keeps what it has and discards everything after it. It never wraps.

The acquisition window is the `shutter` input. A rising edge of `shutter` starts a new acquisition and empties the store. While `shutter` is low, an external slow readout clock `rd_clk` shifts the contents out on `ser_out`, one bit per falling edge. The oldest word goes first, and each word is sent from its top bit down. `rd_clk` is sampled in the `clk` domain through a synchronizer. Each half period of `rd_clk` must therefore last at least `SYNC_STAGES + 2` cycles of `clk`. `empty` shows whether anything has been stored in the current acquisition.

Top module: `event_ser_mem`

## Requirements
- R1: The store holds `DEPTH` = 96 words of `WORD_W` = 72 bits, and its fill count never exceeds 96.
- R2: After 96 words are stored, further events are discarded, and the 96 stored words read out unchanged.
- R3: A rising edge of `shutter` empties the store. After it, `empty` is 1 and readout returns zeros until new words are written.
- R4: An event is stored only when `ev_valid` is 1, the acquisition window has been open for at least one cycle, and the event holds data. In stub mode this means `stub_cnt` is not 0; in raw mode it means `hits` is not all zeros.
- R5: With `ev_mode` = 0 (stub), the word is: bits [71:68] = 1111, [67:52] = `bx`, [51:39] slot 3, [38:26] slot 2, [25:13] slot 1, [12:0] slot 0. Slot k of the word comes from `stubs[13k+12:13k]` when k < `stub_cnt`, and is zero otherwise. A `stub_cnt` above 4 fills all four slots.
- R6: With `ev_mode` = 1 (raw), the word is: bits [71:64] = all ones, [63:48] = `bx`, [47:0] = `hits`. `stubs` and `stub_cnt` have no effect in this mode.
- R7: `empty` is 1 after reset and after each acquisition start. It goes to 0 at the clock edge that stores the first word.
- R8: Readout sends word 1 (the first stored) first and proceeds in storage order. Each word takes 72 consecutive bits, from bit 71 down to bit 0.
- R9: `ser_out` changes only after a falling edge of `rd_clk` seen while `shutter` is low. The new bit appears by the third rising edge of `clk` after that falling edge. Falling edges of `rd_clk` while `shutter` is high do not advance the readout.
- R10: Bit positions beyond the last stored word, including positions past word 96, read out as 0.
- R11: After reset, `ser_out` is 0 and `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shutter | input | 1 | Acquisition window; a rising edge starts a new acquisition |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_mode | input | 1 | Word layout: 0 stub, 1 raw hits |
| stub_cnt | input | 3 | Number of valid stubs in `stubs` |
| stubs | input | 52 | Four 13-bit stubs, slot 0 in the low bits |
| hits | input | 48 | Raw hit vector |
| bx | input | 16 | Bunch-crossing number of the event |
| rd_clk | input | 1 | Slow external readout clock; data advances on its falling edge |
| ser_out | output | 1 | Serial readout data |
| empty | output | 1 | No word stored in the current acquisition |

## Verification
The bench offers a mix of event patterns:
- stub events with one, two and four slots, and one with a count above four, which separate slot masking from the clamp;
- raw events whose stub inputs are non-zero, which show the stub inputs are ignored;
- events with no data or with `ev_valid` low, whose absence from the readout shows they were dropped.

Per-word comparison of the serial stream catches bit-order, word-order and header errors. A run of 100 distinct events checks that the first 96 survive intact and the rest are discarded. `rd_clk` falls while the shutter is high and a fresh acquisition is read back with no events, which separates position resets from stale data.

// File: rtl/evm_pkg.sv
package evm_pkg;
  // Word layout selector
  typedef enum logic {
    EVM_MODE_STUB = 1'b0,
    EVM_MODE_RAW  = 1'b1
  } evm_mode_e;

  // Default geometry shared by the block and its checker
  localparam int EVM_WORD_W  = 72;
  localparam int EVM_DEPTH   = 96;
  localparam int EVM_STUB_W  = 13;
  localparam int EVM_N_STUB  = 4;
  localparam int EVM_HIT_W   = 48;
  localparam int EVM_BX_W    = 16;
  localparam int EVM_SYNC    = 2;
endpackage

// File: rtl/evm_word_build.sv
// Builds the stored word from one event and flags whether it holds data.
module evm_word_build
  import evm_pkg::*;
#(
  parameter int WORD_W = EVM_WORD_W,
  parameter int STUB_W = EVM_STUB_W,
  parameter int N_STUB = EVM_N_STUB,
  parameter int HIT_W  = EVM_HIT_W,
  parameter int BX_W   = EVM_BX_W,
  parameter int SCNT_W = $clog2(N_STUB + 1)
) (
  input  evm_mode_e                  mode,
  input  logic [SCNT_W-1:0]          stub_cnt,
  input  logic [N_STUB*STUB_W-1:0]   stubs,
  input  logic [HIT_W-1:0]           hits,
  input  logic [BX_W-1:0]            bx,
  output logic [WORD_W-1:0]          word,
  output logic                       has_data
);
  localparam int SLOTS_W    = N_STUB * STUB_W;
  localparam int STUB_HDR_W = WORD_W - SLOTS_W - BX_W;
  localparam int RAW_HDR_W  = WORD_W - HIT_W - BX_W;

  logic [SLOTS_W-1:0] slot_word;

  // Slots at or above the stub count are forced to zero
  for (genvar s = 0; s < N_STUB; s++) begin : g_slot
    assign slot_word[s*STUB_W +: STUB_W] =
      (32'(stub_cnt) > s) ? stubs[s*STUB_W +: STUB_W] : '0;
  end

  always_comb begin
    if (mode == EVM_MODE_RAW) begin
      word     = {{RAW_HDR_W{1'b1}}, bx, hits};
      has_data = |hits;
    end else begin
      word     = {{STUB_HDR_W{1'b1}}, bx, slot_word};
      has_data = (stub_cnt != '0);
    end
  end
endmodule

// File: rtl/evm_store.sv
// Fill-once word store: writes in order, stops when full, synchronous read.
module evm_store #(
  parameter int WORD_W = 72,
  parameter int DEPTH  = 96,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q,
  output logic [CNT_W-1:0]  stored_cnt,
  output logic              wr_en,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              full;

  assign full  = (stored_cnt == CNT_W'(DEPTH));
  assign wr_en = wr_req && !full;

  always_ff @(posedge clk) begin
    if (rst || acq_start) begin
      stored_cnt <= '0;
      empty      <= 1'b1;
    end else if (wr_en) begin
      stored_cnt <= stored_cnt + 1'b1;
      empty      <= 1'b0;
    end
  end

  // Plain write/read port without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[stored_cnt[ADDR_W-1:0]] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/evm_ser_reader.sv
// Serialises the store on falling edges of a slow external clock.
module evm_ser_reader #(
  parameter int WORD_W      = 72,
  parameter int DEPTH       = 96,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1),
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start,
  input  logic              shutter,
  input  logic              rd_clk,
  input  logic [CNT_W-1:0]  stored_cnt,
  input  logic [WORD_W-1:0] rd_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_fall,
  output logic              ser_out
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] sync_r;
  logic                   rd_prev;
  logic [CNT_W-1:0]       word_idx;
  logic [BIT_W-1:0]       bit_idx;
  logic                   word_live;

  // Synchroniser and falling-edge detector; idle level is high
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r  <= '1;
      rd_prev <= 1'b1;
    end else begin
      sync_r  <= {sync_r[SYNC_STAGES-2:0], rd_clk};
      rd_prev <= sync_r[SYNC_STAGES-1];
    end
  end

  assign rd_fall   = rd_prev && !sync_r[SYNC_STAGES-1] && !shutter;
  assign word_live = (word_idx < stored_cnt);
  assign rd_addr   = (word_idx < CNT_W'(DEPTH)) ? word_idx[ADDR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst || acq_start) begin
      word_idx <= '0;
      bit_idx  <= BIT_W'(WORD_W - 1);
      ser_out  <= 1'b0;
    end else if (rd_fall) begin
      ser_out <= word_live ? rd_q[bit_idx] : 1'b0;
      if (bit_idx == '0) begin
        bit_idx <= BIT_W'(WORD_W - 1);
        if (word_idx != CNT_W'(DEPTH)) word_idx <= word_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/event_ser_mem.sv
module event_ser_mem
  import evm_pkg::*;
#(
  parameter int WORD_W      = EVM_WORD_W,
  parameter int DEPTH       = EVM_DEPTH,
  parameter int STUB_W      = EVM_STUB_W,
  parameter int N_STUB      = EVM_N_STUB,
  parameter int HIT_W       = EVM_HIT_W,
  parameter int BX_W        = EVM_BX_W,
  parameter int SYNC_STAGES = EVM_SYNC,
  parameter int SCNT_W      = $clog2(N_STUB + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shutter,
  input  logic                     ev_valid,
  input  logic                     ev_mode,
  input  logic [SCNT_W-1:0]        stub_cnt,
  input  logic [N_STUB*STUB_W-1:0] stubs,
  input  logic [HIT_W-1:0]         hits,
  input  logic [BX_W-1:0]          bx,
  input  logic                     rd_clk,
  output logic                     ser_out,
  output logic                     empty
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              shutter_q;
  logic              acq_start;
  logic              acq_on;
  logic [WORD_W-1:0] ev_word;
  logic              has_data;
  logic              wr_req;
  logic              wr_en;
  logic [CNT_W-1:0]  stored_cnt;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_q;
  logic              rd_fall;

  always_ff @(posedge clk) begin
    if (rst) shutter_q <= 1'b0;
    else     shutter_q <= shutter;
  end

  assign acq_start = shutter && !shutter_q;
  assign acq_on    = shutter && shutter_q;
  assign wr_req    = ev_valid && acq_on && has_data;

  evm_word_build #(
    .WORD_W(WORD_W), .STUB_W(STUB_W), .N_STUB(N_STUB),
    .HIT_W(HIT_W), .BX_W(BX_W), .SCNT_W(SCNT_W)
  ) u_build (
    .mode     (evm_mode_e'(ev_mode)),
    .stub_cnt (stub_cnt),
    .stubs    (stubs),
    .hits     (hits),
    .bx       (bx),
    .word     (ev_word),
    .has_data (has_data)
  );

  evm_store #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .acq_start  (acq_start),
    .wr_req     (wr_req),
    .wr_data    (ev_word),
    .rd_addr    (rd_addr),
    .rd_q       (rd_q),
    .stored_cnt (stored_cnt),
    .wr_en      (wr_en),
    .empty      (empty)
  );

  evm_ser_reader #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_reader (
    .clk        (clk),
    .rst        (rst),
    .acq_start  (acq_start),
    .shutter    (shutter),
    .rd_clk     (rd_clk),
    .stored_cnt (stored_cnt),
    .rd_q       (rd_q),
    .rd_addr    (rd_addr),
    .rd_fall    (rd_fall),
    .ser_out    (ser_out)
  );
endmodule

// File: rtl/evm_chk.sv
module evm_chk #(
  parameter int DEPTH = 96,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             acq_start,
  input logic             acq_on,
  input logic             ev_valid,
  input logic             has_data,
  input logic             wr_en,
  input logic             rd_fall,
  input logic [CNT_W-1:0] stored_cnt,
  input logic             empty,
  input logic             ser_out
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    stored_cnt <= CNT_W'(DEPTH)); // R1

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stored_cnt == CNT_W'(DEPTH) && !acq_start) |=> stored_cnt == CNT_W'(DEPTH)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> (empty && stored_cnt == '0)); // R3

  AST_NO_DATA_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && acq_on && !has_data && !acq_start) |=> $stable(stored_cnt)); // R4

  AST_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (stored_cnt != '0) |-> !empty); // R7

  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !acq_start) |=> !empty); // R7

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_fall && !acq_start) |=> $stable(ser_out)); // R9
endmodule

bind event_ser_mem evm_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acq_start  (acq_start),
  .acq_on     (acq_on),
  .ev_valid   (ev_valid),
  .has_data   (has_data),
  .wr_en      (wr_en),
  .rd_fall    (rd_fall),
  .stored_cnt (stored_cnt),
  .empty      (empty),
  .ser_out    (ser_out)
);

// File: tb/event_ser_mem_test.sv
module event_ser_mem_test;
  localparam int WW = 72;
  localparam int DEPTH = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shutter = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_mode = 1'b0;
  logic [2:0]  stub_cnt = '0;
  logic [51:0] stubs = '0;
  logic [47:0] hits = '0;
  logic [15:0] bx = '0;
  logic        rd_clk = 1'b1;
  logic        ser_out;
  logic        empty;

  int checks = 0;
  int fails = 0;
  logic [WW-1:0] exp_q [DEPTH];
  int n_exp = 0;

  always #10 clk = ~clk;

  event_ser_mem uut (
    .clk(clk), .rst(rst), .shutter(shutter), .ev_valid(ev_valid),
    .ev_mode(ev_mode), .stub_cnt(stub_cnt), .stubs(stubs), .hits(hits),
    .bx(bx), .rd_clk(rd_clk), .ser_out(ser_out), .empty(empty)
  );

  // {store, valid, mode, cnt, stubs(slot3..slot0), hits, bx}
  localparam logic [121:0] VEC [9] = '{
    {1'b1, 1'b1, 1'b0, 3'd1, {13'h0, 13'h0, 13'h0, 13'h1ABC}, 48'h0, 16'h0001},
    {1'b1, 1'b1, 1'b1, 3'd0, {4{13'h1555}}, 48'h8000_0000_0001, 16'h0002},
    {1'b0, 1'b1, 1'b0, 3'd0, {4{13'h0777}}, 48'h0, 16'h0003},
    {1'b0, 1'b1, 1'b1, 3'd5, {4{13'h0}}, 48'h0, 16'h0004},
    {1'b0, 1'b0, 1'b0, 3'd4, {13'h1, 13'h2, 13'h3, 13'h4}, 48'h0, 16'h0005},
    {1'b1, 1'b1, 1'b0, 3'd4, {13'h1FFF, 13'h0F0F, 13'h10F0, 13'h0001}, 48'h0, 16'hFFFF},
    {1'b1, 1'b1, 1'b0, 3'd6, {13'h0AAA, 13'h1555, 13'h0123, 13'h1321}, 48'hFFFF_0000_FFFF, 16'h8001},
    {1'b1, 1'b1, 1'b1, 3'd0, {4{13'h0}}, 48'hFFFF_FFFF_FFFF, 16'h0000},
    {1'b1, 1'b1, 1'b0, 3'd2, {13'h1111, 13'h0222, 13'h0333, 13'h0444}, 48'h0, 16'h1234}
  };

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected word from the layout requirements
  function automatic logic [WW-1:0] model(input logic mode, input logic [2:0] cnt,
      input logic [51:0] st, input logic [47:0] h, input logic [15:0] b);
    logic [WW-1:0] w = '0;
    int n = (cnt > 3'd4) ? 4 : int'(cnt);
    if (mode) begin
      w[71:64] = 8'hFF; w[63:48] = b; w[47:0] = h;
    end else begin
      w[71:68] = 4'hF; w[67:52] = b;
      for (int i = 0; i < n; i++) w[i*13 +: 13] = st[i*13 +: 13];
    end
    return w;
  endfunction

  task automatic drive_event(input logic v, input logic m, input logic [2:0] c,
      input logic [51:0] st, input logic [47:0] h, input logic [15:0] b);
    @(negedge clk);
    ev_valid = v; ev_mode = m; stub_cnt = c; stubs = st; hits = h; bx = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic open_shutter();
    @(negedge clk); shutter = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_shutter();
    @(negedge clk); shutter = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_word(output logic [WW-1:0] w);
    for (int b = WW - 1; b >= 0; b--) begin
      rd_clk = 1'b0;
      repeat (4) @(negedge clk);
      w[b] = ser_out;
      rd_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [WW-1:0] w;
    logic          s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(empty === 1'b1, "R11 empty after reset", WW'(empty), WW'(1));
    check(ser_out === 1'b0, "R11 ser_out after reset", WW'(ser_out), WW'(0));

    // Table walk: R4 R5 R6
    open_shutter();
    check(empty === 1'b1, "R7 empty before first write", WW'(empty), WW'(1));
    n_exp = 0;
    for (int i = 0; i < 9; i++) begin
      drive_event(VEC[i][120], VEC[i][119], VEC[i][118:116], VEC[i][115:64],
                  VEC[i][63:16], VEC[i][15:0]);
      if (VEC[i][121]) begin
        exp_q[n_exp] = model(VEC[i][119], VEC[i][118:116], VEC[i][115:64],
                             VEC[i][63:16], VEC[i][15:0]);
        n_exp++;
      end
      if (i == 0) check(empty === 1'b0, "R7 empty after first write", WW'(empty), WW'(0));
    end
    // R9: falling rd_clk while shutter high must not advance readout
    for (int k = 0; k < 3; k++) begin
      rd_clk = 1'b0; repeat (5) @(negedge clk);
      rd_clk = 1'b1; repeat (5) @(negedge clk);
    end
    close_shutter();
    for (int i = 0; i < n_exp; i++) begin
      read_word(w);
      check(w === exp_q[i], "R5/R6/R8 word content and order", w, exp_q[i]);
      if (i == 0) begin
        check(w[71] === 1'b1, "R9 first bit is word 1 bit 71 despite shutter-high falls",
              WW'(w[71]), WW'(1));
        s = ser_out;
        repeat (12) @(negedge clk);
        check(ser_out === s, "R9 ser_out holds without falling edge", WW'(ser_out), WW'(s));
      end
    end
    read_word(w);
    check(w === '0, "R10 word beyond last stored is zero", w, '0);

    // Fill beyond capacity: R1 R2 R10
    open_shutter();
    check(empty === 1'b1, "R3 empty after new acquisition", WW'(empty), WW'(1));
    for (int i = 0; i < DEPTH + 4; i++) begin
      drive_event(1'b1, 1'b0, 3'd1, {39'h0, 13'(i + 1)}, 48'h0, 16'(i + 16'h0100));
      if (i < DEPTH) exp_q[i] = model(1'b0, 3'd1, {39'h0, 13'(i + 1)}, 48'h0, 16'(i + 16'h0100));
    end
    close_shutter();
    begin
      int bad = 0;
      logic [WW-1:0] first_bad_a = '0, first_bad_e = '0;
      for (int i = 0; i < DEPTH; i++) begin
        read_word(w);
        if (w !== exp_q[i] && bad == 0) begin first_bad_a = w; first_bad_e = exp_q[i]; end
        if (w !== exp_q[i]) bad++;
      end
      check(bad == 0, "R1/R2 96 stored words survive overflow", first_bad_a, first_bad_e);
    end
    read_word(w);
    check(w === '0, "R10 position past word 96 reads zero", w, '0);

    // New acquisition with no events: R3
    open_shutter();
    check(empty === 1'b1, "R3 empty after restart", WW'(empty), WW'(1));
    drive_event(1'b1, 1'b1, 3'd0, '0, 48'h0, 16'hABCD);
    check(empty === 1'b1, "R4 raw event without hits not stored", WW'(empty), WW'(1));
    close_shutter();
    read_word(w);
    check(w === '0, "R3 old contents not visible after restart", w, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule